// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K words by 8 bits. The host issues one read or write at a time through a valid/ready handshake. The controller turns each request into registered address, chip-enable, output-enable and read/write strobes. It holds every strobe for enough whole clock cycles to meet the RAM's nanosecond timing minimums. Read data is returned with a one-cycle valid pulse.

Writes are controlled by the read/write line. Both chip enables stay active and output enable stays high for the whole write. The controller's bus driver turns on one cycle after the read/write line falls. It turns off on the same edge where that line rises, so no data hold time is needed. A sleep request deselects the RAM. The RAM then goes to standby and keeps its contents. Leaving standby always passes through a recovery wait before the RAM is selected again, and a request that wakes the RAM is serviced once that wait ends.

All timing limits are parameters in nanoseconds. They are converted to cycle counts from the clock-period parameter and rounded up, with a minimum of one cycle.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_we_n and mem_oe_n are 1, mem_dq_drive is 0, and the RAM is selected (mem_cs_n 0, mem_cs 1).
- R2: A read accepted on edge E drives mem_addr, mem_oe_n=0 and mem_we_n=1 from E. On edge E+RD, rsp_valid is 1 for exactly one cycle and rsp_rdata holds the value the RAM presents at that edge. RD = max(ceil(T_ACC/T), ceil(T_RC/T), ceil(T_OE/T)), which is 5 at defaults with T=8 ns.
- R3: A write accepted on edge E pulls mem_we_n low from E to E+1+P. The address stays unchanged throughout. mem_dq_drive is 1 with constant data from E+1 until the edge where mem_we_n rises. P = max(ceil(T_DS/T), ceil(T_WP/T)-1, ceil(T_WC/T)-2, 1), which is 3 at defaults.
- R4: mem_oe_n is 1 whenever mem_we_n is 0, and mem_dq_drive is never 1 while mem_oe_n is 0.
- R5: req_ready is 0 while an access is in progress. It returns to 1 RD cycles after a read is accepted and 2+P cycles after a write is accepted. Only one request is taken at a time.
- R6: In idle with sleep_req=1 and req_valid=0, the next edge deselects the RAM (mem_cs_n 1, mem_cs 0). The controller leaves mem_we_n and mem_oe_n at 1, keeps mem_dq_drive at 0, and holds req_ready at 0 while asleep.
- R7: In idle, req_valid=1 takes priority over sleep_req=1, and the request is accepted.
- R8: While asleep, the edge W on which req_valid=1 or sleep_req=0 is seen starts a recovery wait. The RAM stays deselected and req_ready stays 0 through edge W+REC-1. Both change on edge W+REC, where REC = ceil(T_REC/T). A waking request is then serviced.
- R9: Data written before standby reads back unchanged after the recovery wait.
- R10: Every timing minimum is a nanosecond parameter converted to cycles by rounding up, never below one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| sleep_req | input | 1 | Ask for RAM standby when idle |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Read/write line, low = write |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_drive | output | 1 | Enables the data bus driver |
| mem_dq_in | input | DATA_W | Data from the RAM |

## Verification
The bench uses addresses at both ends of the range and alternating-bit patterns with complementary data. These show whether address or data bits are swapped or stuck. Reads that follow writes and overwrites of the same word show whether a write commits at the rising read/write edge with the data that was held. The memory model returns a poison value until the access time has elapsed, so a read captured even one cycle early is visible. A request raised together with sleep_req shows the priority rule. Waking by request and waking by dropping sleep_req each measure the exact recovery length, and read-back after standby shows that the contents survived.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END,
        ST_SLEEP,
        ST_WAKE
    } ctrl_state_e;

    // Round a nanosecond minimum up to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 4,
    parameter int RD_LOAD    = 4,
    parameter int PULSE_LOAD = 2,
    parameter int REC_LOAD   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sleep_req,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              cnt_zero,
    output logic              ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              sel,
    output logic              oe_n,
    output logic              we_n,
    output logic              drive,
    output logic [DATA_W-1:0] wdata,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val
);
    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              sel;
        logic              oe_n;
        logic              we_n;
        logic              drive;
        logic              rsp_valid;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        cnt_load      = 1'b0;
        cnt_val       = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    if (req_write) begin
                        // Write strobe falls with the address; setup may be zero.
                        r_d.we_n  = 1'b0;
                        r_d.wdata = req_wdata;
                        r_d.state = ST_WR_SETUP;
                    end else begin
                        r_d.oe_n  = 1'b0;
                        r_d.state = ST_READ;
                        cnt_load  = 1'b1;
                        cnt_val   = CNT_W'(RD_LOAD);
                    end
                end else if (sleep_req) begin
                    r_d.sel   = 1'b0;
                    r_d.state = ST_SLEEP;
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    r_d.rdata     = dq_in;
                    r_d.rsp_valid = 1'b1;
                    r_d.oe_n      = 1'b1;
                    r_d.state     = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                // Driver only turns on once the read/write line has been low a cycle.
                r_d.drive = 1'b1;
                r_d.state = ST_WR_PULSE;
                cnt_load  = 1'b1;
                cnt_val   = CNT_W'(PULSE_LOAD);
            end
            ST_WR_PULSE: begin
                if (cnt_zero) begin
                    // Data held up to the rising edge: zero hold time is allowed.
                    r_d.we_n  = 1'b1;
                    r_d.drive = 1'b0;
                    r_d.state = ST_WR_END;
                end
            end
            ST_WR_END: begin
                r_d.state = ST_IDLE;
            end
            ST_SLEEP: begin
                if (req_valid || !sleep_req) begin
                    r_d.state = ST_WAKE;
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(REC_LOAD);
                end
            end
            ST_WAKE: begin
                if (cnt_zero) begin
                    r_d.sel   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.addr      <= '0;
            r_q.wdata     <= '0;
            r_q.rdata     <= '0;
            r_q.sel       <= 1'b1;
            r_q.oe_n      <= 1'b1;
            r_q.we_n      <= 1'b1;
            r_q.drive     <= 1'b0;
            r_q.rsp_valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.state == ST_IDLE);
    assign rsp_valid = r_q.rsp_valid;
    assign rdata     = r_q.rdata;
    assign addr      = r_q.addr;
    assign sel       = r_q.sel;
    assign oe_n      = r_q.oe_n;
    assign we_n      = r_q.we_n;
    assign drive     = r_q.drive;
    assign wdata     = r_q.wdata;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 8,
    parameter int T_ACC_NS = 40,
    parameter int T_OE_NS  = 25,
    parameter int T_RC_NS  = 40,
    parameter int T_WC_NS  = 40,
    parameter int T_WP_NS  = 30,
    parameter int T_DS_NS  = 20,
    parameter int T_REC_NS = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sleep_req,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC    = max2(max2(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)),
                                    ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int PULSE_CYC = max2(max2(ns_to_cyc(T_DS_NS, CLK_NS), ns_to_cyc(T_WP_NS, CLK_NS) - 1),
                                    max2(ns_to_cyc(T_WC_NS, CLK_NS) - 2, 1));
    localparam int REC_CYC   = ns_to_cyc(T_REC_NS, CLK_NS);
    localparam int CNT_MAX   = max2(max2(RD_CYC, PULSE_CYC), REC_CYC);
    localparam int CNT_W     = max2($clog2(CNT_MAX + 1), 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             sel;

    sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_ctrl_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .RD_LOAD    (RD_CYC - 1),
        .PULSE_LOAD (PULSE_CYC - 1),
        .REC_LOAD   (REC_CYC - 1)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sleep_req (sleep_req),
        .dq_in     (mem_dq_in),
        .cnt_zero  (cnt_zero),
        .ready     (req_ready),
        .rsp_valid (rsp_valid),
        .rdata     (rsp_rdata),
        .addr      (mem_addr),
        .sel       (sel),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .drive     (mem_dq_drive),
        .wdata     (mem_dq_out),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val)
    );

    assign mem_cs_n = ~sel;
    assign mem_cs   = sel;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_drive
);
    a_r2_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r3_addr_held_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    a_r3_drive_after_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_drive) |-> $past(!mem_we_n) && !mem_we_n);

    a_r3_release_with_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_drive) |-> $rose(mem_we_n));

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r4_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_drive);

    a_r5_busy_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !req_ready);

    a_r6_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_drive && !req_ready && !mem_cs));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int AW     = 19;
    localparam int DW     = 8;
    localparam int PER    = 8;
    localparam int REC_NS = 400;

    // Expected cycle counts from the requirement formulas (ceil of ns / 8).
    localparam int ACC_EXP = (40 + PER - 1) / PER;
    localparam int OE_EXP  = (25 + PER - 1) / PER;
    localparam int RD_EXP  = 5;
    localparam int WP_EXP  = (30 + PER - 1) / PER;
    localparam int DS_EXP  = (20 + PER - 1) / PER;
    localparam int P_EXP   = 3;
    localparam int WR_EXP  = 2 + P_EXP;
    localparam int REC_EXP = (REC_NS + PER - 1) / PER;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          sleep_req = 1'b0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_drive;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sram_ctrl #(.T_REC_NS(REC_NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sleep_req(sleep_req),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Behavioural RAM: poison until access time met, commits at rising R/W.
    logic [DW-1:0] mem [int];
    logic [AW-1:0] prev_addr = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] drv_data = '0;
    logic          prev_we_n = 1'b1;
    int addr_age = 0, oe_age = 0, we_low = 0, drv_cnt = 0;
    bit addr_bad = 0, drv_gap = 0;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (mem_dq_drive && !mem_oe_n)
                chk(0, "R4 bus contention", 1, 0);
            addr_age = (mem_addr !== prev_addr) ? 1 : addr_age + 1;
            oe_age   = (!mem_oe_n && !mem_cs_n && mem_cs) ? oe_age + 1 : 0;
            if (!mem_we_n && !mem_cs_n && mem_cs) begin
                if (prev_we_n) begin
                    we_low = 1; drv_cnt = 0; addr_bad = 0; drv_gap = 0; wr_addr = mem_addr;
                end else begin
                    we_low++;
                    if (mem_addr !== prev_addr) addr_bad = 1;
                end
                if (mem_dq_drive) begin
                    if (drv_cnt > 0 && mem_dq_out !== drv_data) drv_cnt = 1;
                    else drv_cnt++;
                    drv_data = mem_dq_out;
                end else if (drv_cnt > 0) begin
                    drv_gap = 1;
                end
                prev_we_n = 1'b0;
            end else begin
                if (!prev_we_n) begin
                    chk(we_low >= WP_EXP, "R3 write pulse cycles", we_low, WP_EXP);
                    chk(drv_cnt >= DS_EXP && !drv_gap, "R3 data setup cycles", drv_cnt, DS_EXP);
                    chk(!addr_bad, "R3 address moved in write", int'(addr_bad), 0);
                    mem[int'(wr_addr)] = drv_data;
                end
                prev_we_n = 1'b1;
            end
            prev_addr = mem_addr;
            if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n &&
                addr_age >= ACC_EXP && oe_age >= OE_EXP)
                mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
            else
                mem_dq_in = 8'hEE;
        end
    end

    // Called at a negedge with the controller idle.
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int busy_err = 0;
        chk(req_ready === 1'b1, "R5 ready before read", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        for (int k = 0; k <= RD_EXP; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_valid = 1'b0;
                chk(mem_oe_n == 1'b0 && mem_we_n == 1'b1 && mem_addr == a,
                    "R2 read strobes", int'(mem_addr), int'(a));
            end
            if (k < RD_EXP && (req_ready !== 1'b0 || rsp_valid !== 1'b0)) busy_err++;
        end
        chk(busy_err == 0, "R5 busy during read", busy_err, 0);
        chk(rsp_valid === 1'b1, "R2 rsp_valid timing", int'(rsp_valid), 1);
        chk(rsp_rdata === exp, "R2 read data", int'(rsp_rdata), int'(exp));
        chk(req_ready === 1'b1, "R5 ready after read", int'(req_ready), 1);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int busy_err = 0;
        chk(req_ready === 1'b1, "R5 ready before write", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        for (int k = 0; k <= WR_EXP; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_valid = 1'b0;
                chk(mem_we_n == 1'b0 && mem_oe_n == 1'b1 && mem_dq_drive == 1'b0,
                    "R3 we low, driver still off", int'(mem_dq_drive), 0);
            end
            if (k == 1)
                chk(mem_dq_drive == 1'b1 && mem_dq_out == d && mem_we_n == 1'b0,
                    "R3 driver on with data", int'(mem_dq_out), int'(d));
            if (k == WR_EXP - 1)
                chk(mem_we_n == 1'b1 && mem_dq_drive == 1'b0,
                    "R3 we high and driver off together", int'(mem_we_n), 1);
            if (k < WR_EXP && req_ready !== 1'b0) busy_err++;
        end
        chk(busy_err == 0, "R5 busy during write", busy_err, 0);
        chk(req_ready === 1'b1, "R5 ready after write", int'(req_ready), 1);
    endtask

    // Called at a negedge while asleep; wake_evt already applied.
    task automatic measure_wake(input string tag);
        int err = 0;
        for (int k = 0; k < REC_EXP; k++) begin
            @(negedge clk);
            if (req_ready !== 1'b0 || mem_cs_n !== 1'b1) err++;
        end
        chk(err == 0, {tag, " held off during recovery"}, err, 0);
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_cs_n === 1'b0 && mem_cs === 1'b1,
            {tag, " ready after recovery"}, int'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 handshake reset", int'(req_ready), 1);
        chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_dq_drive === 1'b0 &&
            mem_cs_n === 1'b0 && mem_cs === 1'b1, "R1 strobes reset", int'(mem_we_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R10: address extremes and alternating patterns
        do_write(19'h00000, 8'hA5);
        do_write(19'h7FFFF, 8'h5A);
        do_write(19'h2AAAA, 8'hFF);
        do_write(19'h55555, 8'h01);
        do_read(19'h00000, 8'hA5);
        do_read(19'h7FFFF, 8'h5A);
        do_read(19'h2AAAA, 8'hFF);
        do_read(19'h55555, 8'h01);
        do_write(19'h2AAAA, 8'h3C);
        do_read(19'h2AAAA, 8'h3C);
        do_read(19'h12345, 8'h00);

        // R7: request and sleep together, request wins
        sleep_req = 1'b1;
        do_read(19'h7FFFF, 8'h5A);

        // R6: controller now drops into standby
        @(negedge clk);
        chk(mem_cs_n === 1'b1 && mem_cs === 1'b0 && req_ready === 1'b0 &&
            mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_dq_drive === 1'b0,
            "R6 standby entry", int'(mem_cs_n), 1);
        repeat (4) @(negedge clk);
        chk(mem_cs_n === 1'b1 && req_ready === 1'b0, "R6 standby held", int'(mem_cs_n), 1);

        // R8 R9: wake by request, then read retained data
        req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00000;
        measure_wake("R8 wake by request");
        do_read(19'h00000, 8'hA5);

        // Back to sleep (sleep_req still high), then wake by dropping it
        repeat (3) @(negedge clk);
        chk(mem_cs_n === 1'b1, "R6 re-entered standby", int'(mem_cs_n), 1);
        sleep_req = 1'b0;
        measure_wake("R8 wake by sleep release");
        do_read(19'h55555, 8'h01);
        do_read(19'h2AAAA, 8'h3C);
        chk(1'b1, "R9 contents kept through standby", 1, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule